// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block is the decision engine of a logic-analyzer trigger path. On every qualified sample it receives one flag per trigger term, each saying whether an upstream comparator matched. The sequencer walks a programmable state machine of up to sixteen states. In each state three independent conditions are formed from those flags: a *hit* condition, an *else* condition and a *capture* condition. Each one picks its own subset of terms and its own logic function.

The hit condition has to be seen a programmed number of times in the current state before it takes effect. When it does, it may fire the trigger, pulse start and stop requests to external timers, and move to the next state. While the hit is still counting, a true else condition sends the machine to any configured state. Until the trigger fires, the capture condition decides which samples the sample memory keeps. After the trigger fires, every sample is kept and the machine holds its state until it is armed again.

Configuration arrives on one wide, static bus holding one record per state. The term evaluators, the timers, the sample memory and the host access all sit outside this block.

Top module: `trig_seq_top`

## Requirements
- R1: Until the first arm after reset the block is idle: state_o is 0 and it gives no trigger, capture or timer output whatever the inputs. A cycle with arm_i high puts the machine, one clock later, in state 0 with the occurrence count cleared and trig_o and capture_o low. Arm takes priority over every other input.
- R2: Each condition takes the terms whose mask bit is set and combines them according to a 3-bit function code: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR (odd parity), 5 XNOR. Codes 6 and 7 are always false. With an empty mask, AND, NOR and XNOR are true and the other codes are false.
- R3: Each state record is SCW = 3*(NUM_TERMS+3)+STATE_W+CNT_W+2+2*NUM_TIMERS bits wide, and state s occupies cfg_i[s*SCW +: SCW]. Fields from bit 0 upward: hit mask, hit code, else mask, else code, capture mask, capture code, else target, hit count, trigger-on-hit bit, advance-on-hit bit, timer-start bits, timer-stop bits.
- R4: A full hit happens on the Nth qualified sample with a true hit condition in the current state, where N is the state's hit count and a count of 0 acts as 1. After a full hit the occurrence count starts again from zero.
- R5: The occurrence count clears whenever the state changes, so hits counted in an earlier visit to a state do not carry over.
- R6: When hit and else are both true on one sample, the hit is taken and the else branch is ignored, even if the count is not yet reached.
- R7: On a full hit, trig_o pulses if the trigger bit is set, and tmr_start_o and tmr_stop_o pulse the state's start and stop bits. If the advance bit is set, the machine moves to state+1; from the last state it stays where it is.
- R8: When else is true and hit is false, the machine moves to the else target. A target at or above NUM_STATES selects the last state.
- R9: Before the trigger, capture_o equals the capture condition of the sample. On the sample that fires the trigger and on every later qualified sample, capture_o is 1.
- R10: Once the trigger has fired, the state is frozen and no further trigger or timer pulses appear until the next arm.
- R11: All outputs are registered and describe the sample presented one clock earlier. Cycles with smp_valid_i low change neither state nor count and give all-zero pulses and capture_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| arm_i | input | 1 | Rearm pulse: restart the sequence in state 0 |
| smp_valid_i | input | 1 | Marks a cycle that carries a sample |
| terms_i | input | NUM_TERMS | Trigger-term match flags for the current sample |
| cfg_i | input | NUM_STATES*SCW | Per-state configuration records (layout in R3) |
| state_o | output | STATE_W | Current sequencer state |
| trig_o | output | 1 | One-cycle trigger (run) pulse |
| capture_o | output | 1 | Store-this-sample enable for the sample memory |
| tmr_start_o | output | NUM_TIMERS | One-cycle timer start requests |
| tmr_stop_o | output | NUM_TIMERS | One-cycle timer stop requests |

## Verification
The hardest situation to reach from the ports is a count that must be discarded: a state collects part of its hit count, leaves through its else branch and later comes back. Only then does a counter that fails to clear on a state change show up, as an early full hit. Random configurations seldom build that round trip, so a directed scenario builds it outright: a state with two exits, a partial count, an else jump, a jump back, and then hits counted one at a time. The other hard cases are advancing from the last state, priority on a sample where both conditions are true, and the frozen state after the trigger. Each is set up directly. Seeded random configurations with sparse term masks and small counts then run long arm-to-trigger sequences against a bench reference model.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  localparam int unsigned FN_W = 3;

  // condition slots inside one state record
  localparam int unsigned CI_HIT = 0;
  localparam int unsigned CI_ELS = 1;
  localparam int unsigned CI_CAP = 2;
  localparam int unsigned N_COND = 3;

  typedef enum logic [FN_W-1:0] {
    FN_AND  = 3'd0,
    FN_NAND = 3'd1,
    FN_OR   = 3'd2,
    FN_NOR  = 3'd3,
    FN_XOR  = 3'd4,
    FN_XNOR = 3'd5
  } cond_fn_e;

  function automatic int unsigned state_cfg_width(int unsigned terms, int unsigned sw,
                                                  int unsigned cw, int unsigned nt);
    return N_COND * (terms + FN_W) + sw + cw + 2 + 2 * nt;
  endfunction

endpackage

// File: rtl/trig_seq_rst_sync.sv
module trig_seq_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/trig_seq_cond.sv
module trig_seq_cond
  import trig_seq_pkg::*;
#(
  parameter int unsigned NUM_TERMS = 16
) (
  input  logic [NUM_TERMS-1:0] terms_i,
  input  logic [NUM_TERMS-1:0] mask_i,
  input  logic [FN_W-1:0]      fn_i,
  output logic                 match_o
);
  logic [NUM_TERMS-1:0] sel;
  logic all_set;
  logic any_set;
  logic odd_set;

  assign sel     = terms_i & mask_i;
  assign all_set = &(terms_i | ~mask_i);
  assign any_set = |sel;
  assign odd_set = ^sel;

  always_comb begin
    case (fn_i)
      FN_AND:  match_o = all_set;
      FN_NAND: match_o = ~all_set;
      FN_OR:   match_o = any_set;
      FN_NOR:  match_o = ~any_set;
      FN_XOR:  match_o = odd_set;
      FN_XNOR: match_o = ~odd_set;
      default: match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_seq_cfg_sel.sv
module trig_seq_cfg_sel
  import trig_seq_pkg::*;
#(
  parameter int unsigned NUM_TERMS  = 16,
  parameter int unsigned NUM_STATES = 16,
  parameter int unsigned STATE_W    = 4,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned NUM_TIMERS = 2,
  localparam int unsigned SCW       = state_cfg_width(NUM_TERMS, STATE_W, CNT_W, NUM_TIMERS)
) (
  input  logic [NUM_STATES*SCW-1:0]             cfg_i,
  input  logic [STATE_W-1:0]                    state_i,
  output logic [N_COND-1:0][NUM_TERMS-1:0]      mask_o,
  output logic [N_COND-1:0][FN_W-1:0]           fn_o,
  output logic [STATE_W-1:0]                    tgt_o,
  output logic [CNT_W-1:0]                      limit_o,
  output logic                                  act_trg_o,
  output logic                                  act_adv_o,
  output logic [NUM_TIMERS-1:0]                 act_tst_o,
  output logic [NUM_TIMERS-1:0]                 act_tsp_o
);
  localparam int unsigned COND_W  = NUM_TERMS + FN_W;
  localparam int unsigned OFF_TGT = N_COND * COND_W;
  localparam int unsigned OFF_CNT = OFF_TGT + STATE_W;
  localparam int unsigned OFF_TRG = OFF_CNT + CNT_W;
  localparam int unsigned OFF_ADV = OFF_TRG + 1;
  localparam int unsigned OFF_TST = OFF_ADV + 1;
  localparam int unsigned OFF_TSP = OFF_TST + NUM_TIMERS;

  logic [SCW-1:0] rec;

  assign rec = cfg_i[int'(state_i)*SCW +: SCW];

  for (genvar k = 0; k < N_COND; k++) begin : g_field
    assign mask_o[k] = rec[k*COND_W +: NUM_TERMS];
    assign fn_o[k]   = rec[k*COND_W + NUM_TERMS +: FN_W];
  end

  assign tgt_o     = rec[OFF_TGT +: STATE_W];
  assign limit_o   = rec[OFF_CNT +: CNT_W];
  assign act_trg_o = rec[OFF_TRG];
  assign act_adv_o = rec[OFF_ADV];
  assign act_tst_o = rec[OFF_TST +: NUM_TIMERS];
  assign act_tsp_o = rec[OFF_TSP +: NUM_TIMERS];
endmodule

// File: rtl/trig_seq_occ.sv
module trig_seq_occ #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim_eff;
  logic [CNT_W:0]   cnt_inc;
  logic             reached;
  logic             cnt_en;

  // a programmed count of zero behaves as one
  assign lim_eff = (limit_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : limit_i;
  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign reached = cnt_inc >= {1'b0, lim_eff};
  assign full_o  = inc_i & reached;
  assign cnt_en  = clr_i | inc_i;

  always_comb begin
    if (clr_i)        cnt_d = '0;
    else if (reached) cnt_d = '0;
    else              cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_FULL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
  import trig_seq_pkg::*;
#(
  parameter int unsigned NUM_TERMS  = 16,
  parameter int unsigned NUM_STATES = 16,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned NUM_TIMERS = 2,
  localparam int unsigned STATE_W   = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1,
  localparam int unsigned SCW       = state_cfg_width(NUM_TERMS, STATE_W, CNT_W, NUM_TIMERS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm_i,
  input  logic                       smp_valid_i,
  input  logic [NUM_TERMS-1:0]       terms_i,
  input  logic [NUM_STATES*SCW-1:0]  cfg_i,
  output logic [STATE_W-1:0]         state_o,
  output logic                       trig_o,
  output logic                       capture_o,
  output logic [NUM_TIMERS-1:0]      tmr_start_o,
  output logic [NUM_TIMERS-1:0]      tmr_stop_o
);
  localparam logic [STATE_W-1:0] LAST_ST = STATE_W'(NUM_STATES - 1);

  logic rst_ns;

  logic [STATE_W-1:0]    state_q, state_d;
  logic                  armed_q, armed_d;
  logic                  fired_q, fired_d;
  logic                  trig_q, trig_d;
  logic                  cap_q, cap_d;
  logic [NUM_TIMERS-1:0] tst_q, tst_d;
  logic [NUM_TIMERS-1:0] tsp_q, tsp_d;
  logic                  ctl_en;

  logic [N_COND-1:0][NUM_TERMS-1:0] cond_mask;
  logic [N_COND-1:0][FN_W-1:0]      cond_fn;
  logic [N_COND-1:0]                cond_hit;
  logic [STATE_W-1:0]               cfg_tgt;
  logic [STATE_W-1:0]               tgt_eff;
  logic [CNT_W-1:0]                 cfg_limit;
  logic                             act_trg;
  logic                             act_adv;
  logic [NUM_TIMERS-1:0]            act_tst;
  logic [NUM_TIMERS-1:0]            act_tsp;

  logic             step;
  logic             occ_clr;
  logic             occ_inc;
  logic             occ_full;
  logic [CNT_W-1:0] occ_cnt;

  trig_seq_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ns)
  );

  trig_seq_cfg_sel #(
    .NUM_TERMS  (NUM_TERMS),
    .NUM_STATES (NUM_STATES),
    .STATE_W    (STATE_W),
    .CNT_W      (CNT_W),
    .NUM_TIMERS (NUM_TIMERS)
  ) u_cfg_sel (
    .cfg_i     (cfg_i),
    .state_i   (state_q),
    .mask_o    (cond_mask),
    .fn_o      (cond_fn),
    .tgt_o     (cfg_tgt),
    .limit_o   (cfg_limit),
    .act_trg_o (act_trg),
    .act_adv_o (act_adv),
    .act_tst_o (act_tst),
    .act_tsp_o (act_tsp)
  );

  for (genvar k = 0; k < N_COND; k++) begin : g_cond
    trig_seq_cond #(
      .NUM_TERMS (NUM_TERMS)
    ) u_cond (
      .terms_i (terms_i),
      .mask_i  (cond_mask[k]),
      .fn_i    (cond_fn[k]),
      .match_o (cond_hit[k])
    );
  end

  // out-of-range else targets fold onto the last state
  if ((2 ** STATE_W) != NUM_STATES) begin : g_tgt_clamp
    assign tgt_eff = (cfg_tgt > LAST_ST) ? LAST_ST : cfg_tgt;
  end else begin : g_tgt_pass
    assign tgt_eff = cfg_tgt;
  end

  assign step    = armed_q & ~fired_q & smp_valid_i & ~arm_i;
  assign occ_inc = step & cond_hit[CI_HIT];

  trig_seq_occ #(
    .CNT_W (CNT_W)
  ) u_occ (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clr_i   (occ_clr),
    .inc_i   (occ_inc),
    .limit_i (cfg_limit),
    .full_o  (occ_full),
    .cnt_o   (occ_cnt)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    fired_d = fired_q;
    trig_d  = 1'b0;
    cap_d   = 1'b0;
    tst_d   = '0;
    tsp_d   = '0;
    occ_clr = 1'b0;
    if (arm_i) begin
      armed_d = 1'b1;
      fired_d = 1'b0;
      state_d = '0;
      occ_clr = 1'b1;
    end else if (armed_q && smp_valid_i) begin
      if (fired_q) begin
        cap_d = 1'b1;
      end else begin
        cap_d = cond_hit[CI_CAP];
        if (cond_hit[CI_HIT]) begin
          if (occ_full) begin
            trig_d = act_trg;
            fired_d = act_trg;
            cap_d = cond_hit[CI_CAP] | act_trg;
            tst_d = act_tst;
            tsp_d = act_tsp;
            if (act_adv && (state_q != LAST_ST)) begin
              state_d = state_q + STATE_W'(1);
            end
          end
        end else if (cond_hit[CI_ELS]) begin
          state_d = tgt_eff;
          occ_clr = 1'b1;
        end
      end
    end
  end

  assign ctl_en = arm_i | step;

  // registers: control state only moves on arm or a live sample
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      armed_q <= armed_d;
      fired_q <= fired_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      trig_q <= 1'b0;
      cap_q  <= 1'b0;
      tst_q  <= '0;
      tsp_q  <= '0;
    end else begin
      trig_q <= trig_d;
      cap_q  <= cap_d;
      tst_q  <= tst_d;
      tsp_q  <= tsp_d;
    end
  end

  assign state_o     = state_q;
  assign trig_o      = trig_q;
  assign capture_o   = cap_q;
  assign tmr_start_o = tst_q;
  assign tmr_stop_o  = tsp_q;

  AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (!rst_ns)
    arm_i |=> (state_q == '0) && !trig_o && !capture_o && (occ_cnt == '0)); // R1

  AST_MOVE_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q != $past(state_q)) |-> (occ_cnt == '0)); // R5

  AST_FROZEN_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_ns)
    (fired_q && !arm_i) |=> $stable(state_q) && !trig_o && (tmr_start_o == '0)); // R10

  AST_CAPTURE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_ns)
    (fired_q && smp_valid_i && !arm_i) |=> capture_o); // R9

  AST_NO_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    (!smp_valid_i && !arm_i) |=> !capture_o && !trig_o && (tmr_start_o == '0) && (tmr_stop_o == '0)); // R11

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_ns)
    trig_o |=> !trig_o); // R10
endmodule

// File: tb/trig_seq_top_tb.sv
`timescale 1ns/1ps
module trig_seq_top_tb;
  localparam int T   = 16;
  localparam int S   = 16;
  localparam int CW  = 20;
  localparam int NT  = 2;
  localparam int SW  = 4;
  // R3 record layout
  localparam int SCW   = 3*(T+3) + SW + CW + 2 + 2*NT;
  localparam int O_TGT = 3*(T+3);
  localparam int O_CNT = O_TGT + SW;
  localparam int O_TRG = O_CNT + CW;
  localparam int O_ADV = O_TRG + 1;
  localparam int O_TST = O_ADV + 1;
  localparam int O_TSP = O_TST + NT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [T-1:0] terms_i = '0;
  logic [S*SCW-1:0] cfg = '0;
  logic [SW-1:0] state_o;
  logic trig_o, capture_o;
  logic [NT-1:0] tmr_start_o, tmr_stop_o;

  int total = 0;
  int fails = 0;

  // reference model
  int m_state = 0;
  int m_cnt = 0;
  bit m_armed = 0;
  bit m_fired = 0;
  bit e_trig = 0;
  bit e_cap = 0;
  logic [NT-1:0] e_tst = '0;
  logic [NT-1:0] e_tsp = '0;

  always #2.5 clk = ~clk;

  trig_seq_top #(
    .NUM_TERMS(T), .NUM_STATES(S), .CNT_W(CW), .NUM_TIMERS(NT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .smp_valid_i(smp_valid_i),
    .terms_i(terms_i), .cfg_i(cfg), .state_o(state_o), .trig_o(trig_o),
    .capture_o(capture_o), .tmr_start_o(tmr_start_o), .tmr_stop_o(tmr_stop_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit cond_eval(input logic [T-1:0] t, input logic [T-1:0] m, input logic [2:0] f);
    logic [T-1:0] s;
    s = t & m;
    case (f) // R2 codes
      3'd0: return (s == m);
      3'd1: return (s != m);
      3'd2: return (s != '0);
      3'd3: return (s == '0);
      3'd4: return ^s;
      3'd5: return ~^s;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_state(input int s, input logic [T-1:0] hm, input logic [2:0] hf,
                           input logic [T-1:0] em, input logic [2:0] ef,
                           input logic [T-1:0] cm, input logic [2:0] cf,
                           input logic [SW-1:0] tgt, input logic [CW-1:0] cnt,
                           input logic trg, input logic adv,
                           input logic [NT-1:0] tst, input logic [NT-1:0] tsp);
    cfg[s*SCW +: SCW] = {tsp, tst, adv, trg, cnt, tgt, cf, cm, ef, em, hf, hm};
  endtask

  task automatic clear_cfg();
    for (int s = 0; s < S; s++)
      set_state(s, '0, 3'd6, '0, 3'd6, '0, 3'd6, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic step(input bit arm, input bit vld, input logic [T-1:0] t);
    logic [SCW-1:0] rec;
    bit h, e, c;
    int lim;
    arm_i = arm;
    smp_valid_i = vld;
    terms_i = t;
    e_trig = 0; e_cap = 0; e_tst = '0; e_tsp = '0;
    if (arm) begin
      m_armed = 1; m_fired = 0; m_state = 0; m_cnt = 0;
    end else if (m_armed && vld) begin
      if (m_fired) e_cap = 1;
      else begin
        rec = cfg[m_state*SCW +: SCW];
        h = cond_eval(t, rec[0 +: T], rec[T +: 3]);
        e = cond_eval(t, rec[T+3 +: T], rec[2*T+3 +: 3]);
        c = cond_eval(t, rec[2*T+6 +: T], rec[3*T+6 +: 3]);
        e_cap = c;
        if (h) begin
          lim = int'(rec[O_CNT +: CW]);
          if (lim == 0) lim = 1;
          if (m_cnt + 1 >= lim) begin
            m_cnt = 0;
            e_tst = rec[O_TST +: NT];
            e_tsp = rec[O_TSP +: NT];
            if (rec[O_TRG]) begin e_trig = 1; m_fired = 1; e_cap = 1; end
            if (rec[O_ADV] && m_state != S-1) m_state++;
          end else m_cnt++;
        end else if (e) begin
          m_state = int'(rec[O_TGT +: SW]);
          m_cnt = 0;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(int'(state_o) == m_state, "R8 state", state_o, m_state);
    chk(trig_o == e_trig, "R7 trig", trig_o, e_trig);
    chk(capture_o == e_cap, "R9 capture", capture_o, e_cap);
    chk(tmr_start_o == e_tst, "R7 timer start", tmr_start_o, e_tst);
    chk(tmr_stop_o == e_tsp, "R7 timer stop", tmr_stop_o, e_tsp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h5EED_0042);
    clear_cfg();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_o == '0 && !trig_o && !capture_o, "R1 reset idle", {state_o, trig_o, capture_o}, 0);

    // R1: unarmed machine ignores an always-true hit with trigger
    set_state(0, '0, 3'd0, '0, 3'd6, '0, 3'd3, '0, 20'd0, 1'b1, 1'b1, 2'b11, 2'b11);
    step(0, 1, 16'h0001);
    chk(!trig_o && !capture_o && tmr_start_o == '0, "R1 unarmed quiet", trig_o, 0);

    // R4: count of three, with an invalid cycle in between (R11)
    clear_cfg();
    set_state(0, 16'h0001, 3'd0, '0, 3'd6, '0, 3'd6, '0, 20'd3, 1'b1, 1'b0, '0, '0);
    step(1, 0, '0);
    chk(state_o == '0 && !trig_o && !capture_o, "R1 arm", state_o, 0);
    step(0, 1, 16'h0001);
    step(0, 0, 16'h0001);
    chk(!capture_o && !trig_o, "R11 invalid ignored", capture_o, 0);
    step(0, 1, 16'h0000);
    step(0, 1, 16'h0001);
    chk(!trig_o, "R4 second hit", trig_o, 0);
    step(0, 1, 16'h0001);
    chk(trig_o, "R4 third hit fires", trig_o, 1);
    step(0, 1, 16'h0000);
    chk(capture_o && !trig_o, "R10 capture held, no repeat", {capture_o, trig_o}, 2);

    // R4: count zero acts as one
    set_state(0, 16'h0001, 3'd0, '0, 3'd6, '0, 3'd6, '0, 20'd0, 1'b1, 1'b0, '0, '0);
    step(1, 0, '0);
    step(0, 1, 16'h0001);
    chk(trig_o, "R4 zero count", trig_o, 1);

    // R5 R6 R8: partial count, else round trip, counter restart
    clear_cfg();
    set_state(0, 16'h0001, 3'd2, 16'h0002, 3'd2, '0, 3'd6, 4'd5, 20'd2, 1'b0, 1'b1, '0, '0);
    set_state(5, '0, 3'd6, 16'h0004, 3'd2, '0, 3'd6, 4'd0, 20'd1, 1'b0, 1'b0, '0, '0);
    step(1, 0, '0);
    step(0, 1, 16'h0003);
    chk(state_o == 4'd0, "R6 hit beats else", state_o, 0);
    step(0, 1, 16'h0002);
    chk(state_o == 4'd5, "R8 else jump", state_o, 5);
    step(0, 1, 16'h0004);
    step(0, 1, 16'h0001);
    chk(state_o == 4'd0, "R5 count cleared on move", state_o, 0);
    step(0, 1, 16'h0001);
    chk(state_o == 4'd1, "R7 advance", state_o, 1);

    // R2: invalid codes, NOR, XNOR
    clear_cfg();
    set_state(0, 16'hFFFF, 3'd6, '0, 3'd6, '0, 3'd6, '0, 20'd1, 1'b0, 1'b1, '0, '0);
    step(1, 0, '0);
    step(0, 1, 16'hFFFF);
    chk(state_o == 4'd0, "R2 code 6 false", state_o, 0);
    set_state(0, 16'hFFFF, 3'd7, '0, 3'd6, '0, 3'd6, '0, 20'd1, 1'b0, 1'b1, '0, '0);
    step(0, 1, 16'hFFFF);
    chk(state_o == 4'd0, "R2 code 7 false", state_o, 0);
    set_state(0, 16'hFFFF, 3'd3, '0, 3'd6, '0, 3'd6, '0, 20'd1, 1'b0, 1'b1, '0, '0);
    set_state(1, 16'h0003, 3'd5, '0, 3'd6, '0, 3'd6, '0, 20'd1, 1'b0, 1'b1, '0, '0);
    step(0, 1, 16'h0000);
    chk(state_o == 4'd1, "R2 NOR true", state_o, 1);
    step(0, 1, 16'h0001);
    chk(state_o == 4'd1, "R2 XNOR odd false", state_o, 1);
    step(0, 1, 16'h0003);
    chk(state_o == 4'd2, "R2 XNOR even true", state_o, 2);

    // R7 R3: last state does not advance, timer fields
    clear_cfg();
    set_state(0, '0, 3'd6, 16'h0001, 3'd2, '0, 3'd6, 4'd15, 20'd1, 1'b0, 1'b0, '0, '0);
    set_state(15, 16'h0001, 3'd2, '0, 3'd6, '0, 3'd6, '0, 20'd1, 1'b0, 1'b1, 2'b01, 2'b10);
    step(1, 0, '0);
    step(0, 1, 16'h0001);
    step(0, 1, 16'h0001);
    chk(state_o == 4'd15, "R7 last state holds", state_o, 15);
    chk(tmr_start_o == 2'b01 && tmr_stop_o == 2'b10, "R3 timer fields", {tmr_start_o, tmr_stop_o}, 6);

    // R9 R10 R11 R1: capture before and after fire, frozen state, rearm
    clear_cfg();
    set_state(0, 16'h0001, 3'd2, 16'h0004, 3'd2, 16'h0002, 3'd2, 4'd3, 20'd1, 1'b1, 1'b0, '0, '0);
    step(1, 0, '0);
    step(0, 1, 16'h0002);
    chk(capture_o, "R9 capture true", capture_o, 1);
    step(0, 1, 16'h0000);
    chk(!capture_o, "R9 capture false", capture_o, 0);
    step(0, 1, 16'h0001);
    chk(trig_o && capture_o, "R9 fire sample captured", {trig_o, capture_o}, 3);
    step(0, 1, 16'h0004);
    chk(state_o == 4'd0 && capture_o, "R10 frozen after fire", state_o, 0);
    step(0, 0, 16'h0000);
    chk(!capture_o, "R11 no sample no capture", capture_o, 0);
    step(1, 0, '0);
    chk(state_o == '0 && !capture_o && !trig_o, "R1 rearm", state_o, 0);

    // seeded random configurations
    for (int r = 0; r < 25; r++) begin
      for (int s = 0; s < S; s++)
        set_state(s, T'($urandom & $urandom & $urandom), 3'($urandom),
                  T'($urandom & $urandom & $urandom), 3'($urandom),
                  T'($urandom & $urandom), 3'($urandom),
                  SW'($urandom), CW'($urandom % 4),
                  1'(($urandom % 4) == 0), 1'($urandom), NT'($urandom), NT'($urandom));
      step(1, 0, '0);
      for (int c = 0; c < 300; c++)
        step(($urandom % 100) == 0, ($urandom % 4) != 0, T'($urandom));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule